// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Front End

This block is the target side of a two-wire serial memory bus. It watches already-synchronised clock and data lines, recognises bus start and stop conditions, and shifts in bytes most significant bit first. The first byte after a start is a control byte. Its upper nibble must equal a fixed device code. The next three bits are ignored, and the last bit gives the transfer direction.

For a write, the block acknowledges the control byte. It then loads the next byte into an internal word pointer. Each data byte that follows is handed to the memory write path as a one-cycle strobe carrying the pointer value and the byte. After each data byte, the low bits of the pointer step within a page. A stop after at least one data byte raises a commit pulse, which starts the nonvolatile write elsewhere.

While that write is in progress, a busy input makes the block ignore its own address, so the bus master can poll for completion. A matched read request is acknowledged and signalled to the read side. The block itself returns no read data.

Top module: `twm_target`

## Requirements
- R1: While reset is applied and after its release, `sda_oe_n` is 1 and `wr_stb_o`, `rd_sel_o` and `commit_o` are 0 until bus activity causes them to change.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one discards any partly received byte. A new start in the middle of a byte begins a fresh control byte.
- R3: Data bits are sampled on SCL rising edges, most significant bit first. `sda_oe_n` changes only while SCL is low.
- R4: The control byte matches when its bits 7..4 equal `DEV_CODE` (default 4'b1010). Bits 3..1 are don't care. Bit 0 is the direction: 0 means write and 1 means read.
- R5: An acknowledge drives `sda_oe_n` to 0 from the SCL fall after the eighth bit until the SCL fall after the ninth bit, so it covers exactly the ninth SCL high period.
- R6: A control byte that does not match is not acknowledged. The block then ignores all bus bytes until the next start, with no strobe and no commit.
- R7: If `busy_i` is 1 when the control byte completes, the byte is not acknowledged and is handled like a mismatch.
- R8: A matched read control byte is acknowledged, and `rd_sel_o` pulses for one cycle. Later bytes are not acknowledged until the next start.
- R9: In a write, the byte after the control byte is loaded into the word pointer and acknowledged.
- R10: Each later data byte is acknowledged. `wr_stb_o` pulses for one cycle, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte.
- R11: After each data byte, the low `PAGE_BITS` bits of the pointer increment with wraparound and the upper bits stay the same. With the default of 3, address 8'h3F is followed by 8'h38.
- R12: A stop after at least one data byte since the last start pulses `commit_o` for one cycle. A stop without any data byte does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| busy_i | input | 1 | Nonvolatile write cycle in progress |
| sda_oe_n | output | 1 | Active-low pull-down enable for SDA |
| wr_stb_o | output | 1 | One-cycle data byte strobe |
| wr_addr_o | output | 8 | Word address for the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle pulse starting the write cycle |
| rd_sel_o | output | 1 | One-cycle pulse for an accepted read request |

## Verification
The bench builds the block with `DEV_CODE` = 4'b1010 and `PAGE_BITS` = 3. With an eight-byte page, a write of three bytes starting at 8'h3E crosses the page boundary, which shows that the pointer wraps and the upper bits stay fixed. It also sends control bytes with the select bits set, a wrong device code, the busy input high, and the read direction. It sends a start in the middle of a byte and a stop that follows only an address. For each case it checks the acknowledge level during every ninth clock and the write, read and commit pulses.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CTRL  = 2'd1,
    ST_WADDR = 2'd2,
    ST_WDATA = 2'd3
  } twm_state_e;
endpackage

// File: rtl/twm_bus_cond.sv
module twm_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl;
    sda_d = sda;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    scl_rise  = scl & ~scl_q;
    scl_fall  = ~scl & scl_q;
    start_det = scl & scl_q & sda_q & ~sda;
    stop_det  = scl & scl_q & ~sda_q & sda;
  end
endmodule

// File: rtl/twm_shifter.sv
module twm_shifter
  import twm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              full
);
  logic [BYTE_W-1:0] data_d;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    data_d = data_q;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en) begin
      data_d = {data_q[BYTE_W-2:0], bit_in};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr || shift_en) begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign full = (cnt_q == CNT_W'(BYTE_W));

  // R3: every sampled bit advances the count by one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/twm_word_ptr.sv
module twm_word_ptr
  import twm_pkg::*;
#(
  parameter int PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              step,
  output logic [BYTE_W-1:0] ptr_q
);
  logic [BYTE_W-1:0] ptr_d;
  logic [BYTE_W-1:0] ptr_step;

  generate
    if (PAGE_BITS >= BYTE_W) begin : g_flat
      assign ptr_step = ptr_q + 1'b1;
    end else begin : g_paged
      logic [PAGE_BITS-1:0] low_next;
      assign low_next = ptr_q[PAGE_BITS-1:0] + 1'b1;
      assign ptr_step = {ptr_q[BYTE_W-1:PAGE_BITS], low_next};

      // R11: stepping never alters the page bits
      assert_page_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr_q[BYTE_W-1:PAGE_BITS] == $past(ptr_q[BYTE_W-1:PAGE_BITS])));
    end
  endgenerate

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_val;
    else if (step) ptr_d = ptr_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ptr_q <= '0;
    else if (load || step)  ptr_q <= ptr_d;
  end
endmodule

// File: rtl/twm_target.sv
module twm_target
  import twm_pkg::*;
#(
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  output logic              sda_oe_n,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              rd_sel_o
);
  localparam logic [BYTE_W-1:0] CODE_MASK = {4'hF, {(BYTE_W-4){1'b0}}};
  localparam logic [BYTE_W-1:0] CODE_REF  = {DEV_CODE, {(BYTE_W-4){1'b0}}};

  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  twm_bus_cond u_cond (
    .clk(clk), .rst_n(rst_s), .scl(scl_i), .sda(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic              sh_clr, sh_en, byte_full;
  logic [BYTE_W-1:0] sh_data;
  logic [CNT_W-1:0]  sh_cnt;
  twm_shifter u_shift (
    .clk(clk), .rst_n(rst_s), .clr(sh_clr), .shift_en(sh_en), .bit_in(sda_i),
    .data_q(sh_data), .cnt_q(sh_cnt), .full(byte_full)
  );

  logic              ptr_ld, ptr_inc;
  logic [BYTE_W-1:0] ptr;
  twm_word_ptr #(.PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_s), .load(ptr_ld), .load_val(sh_data),
    .step(ptr_inc), .ptr_q(ptr)
  );

  twm_state_e        state_q, state_d;
  logic              ack_q, ack_d;
  logic              got_q, got_d;
  logic              stb_q, stb_d;
  logic              rd_q, rd_d;
  logic              cmt_q, cmt_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic [BYTE_W-1:0] waddr_q, waddr_d;
  logic              eval_ctrl;
  logic              code_hit;

  assign code_hit = ((sh_data & CODE_MASK) == CODE_REF);

  always_comb begin
    state_d   = state_q;
    ack_d     = ack_q;
    got_d     = got_q;
    stb_d     = 1'b0;
    rd_d      = 1'b0;
    cmt_d     = 1'b0;
    wdata_d   = wdata_q;
    waddr_d   = waddr_q;
    sh_clr    = 1'b0;
    sh_en     = 1'b0;
    ptr_ld    = 1'b0;
    ptr_inc   = 1'b0;
    eval_ctrl = 1'b0;
    if (start_det) begin
      state_d = ST_CTRL;
      ack_d   = 1'b0;
      got_d   = 1'b0;
      sh_clr  = 1'b1;
    end else if (stop_det) begin
      cmt_d   = got_q;
      got_d   = 1'b0;
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      sh_clr  = 1'b1;
    end else if (ack_q) begin
      if (scl_fall) begin
        ack_d  = 1'b0;
        sh_clr = 1'b1;
      end
    end else if (state_q != ST_IDLE) begin
      if (scl_rise && !byte_full) begin
        sh_en = 1'b1;
      end else if (scl_fall && byte_full) begin
        case (state_q)
          ST_CTRL: begin
            eval_ctrl = 1'b1;
            if (code_hit && !busy_i) begin
              ack_d = 1'b1;
              if (sh_data[0]) begin
                rd_d    = 1'b1;
                state_d = ST_IDLE;
              end else begin
                state_d = ST_WADDR;
              end
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_WADDR: begin
            ptr_ld  = 1'b1;
            ack_d   = 1'b1;
            state_d = ST_WDATA;
          end
          ST_WDATA: begin
            stb_d   = 1'b1;
            wdata_d = sh_data;
            waddr_d = ptr;
            ptr_inc = 1'b1;
            got_d   = 1'b1;
            ack_d   = 1'b1;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      got_q   <= 1'b0;
      stb_q   <= 1'b0;
      rd_q    <= 1'b0;
      cmt_q   <= 1'b0;
      wdata_q <= '0;
      waddr_q <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      got_q   <= got_d;
      stb_q   <= stb_d;
      rd_q    <= rd_d;
      cmt_q   <= cmt_d;
      if (stb_d) begin
        wdata_q <= wdata_d;
        waddr_q <= waddr_d;
      end
    end
  end

  assign sda_oe_n  = ~ack_q;
  assign wr_stb_o  = stb_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;
  assign commit_o  = cmt_q;
  assign rd_sel_o  = rd_q;

  // R3: the data line drive moves only during the SCL low phase
  assert_drive_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(sda_oe_n) |-> !$past(scl_i));

  // R7: a busy write cycle keeps the target silent on its own address
  assert_busy_silent_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (eval_ctrl && busy_i) |=> sda_oe_n);

  // R5: a released acknowledge leaves the bit counter at the start of a byte
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(sda_oe_n) |-> (sh_cnt == '0));

  // R10: the write, read and commit pulses never coincide
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({wr_stb_o, rd_sel_o, commit_o}));
endmodule

// File: tb/twm_target_test.sv
`timescale 1ns/1ps
module twm_target_test;
  logic clk, rst_n, scl, sda_m, busy;
  logic sda_bus;
  logic oe_n, stb, cmt, rdsel;
  logic [7:0] waddr, wdata;

  int total = 0, bad = 0;
  int stb_cnt = 0, cmt_cnt = 0, rd_cnt = 0;
  logic [7:0] last_a, last_d;
  localparam int Q = 10;

  assign sda_bus = sda_m & oe_n;

  twm_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .busy_i(busy),
    .sda_oe_n(oe_n), .wr_stb_o(stb), .wr_addr_o(waddr), .wr_data_o(wdata),
    .commit_o(cmt), .rd_sel_o(rdsel)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (stb) begin stb_cnt <= stb_cnt + 1; last_a <= waddr; last_d <= wdata; end
    if (cmt) cmt_cnt <= cmt_cnt + 1;
    if (rdsel) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic put_bit(input logic b, output logic oe_seen);
    sda_m = b; wt(Q); scl = 1'b1; wt(Q); oe_seen = oe_n; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic o, any_low;
    any_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      put_bit(b[i], o);
      if (!o) any_low = 1'b1;
    end
    chk({req, " no drive during data bits (R3)"}, any_low, 0);
    put_bit(1'b1, o);
    chk({req, " ninth clock level (R5)"}, o, exp_ack ? 0 : 1);
  endtask

  task automatic t_reset;
    chk("R1 oe_n after reset", oe_n, 1);
    chk("R1 pulses quiet", stb_cnt + cmt_cnt + rd_cnt, 0);
  endtask

  task automatic t_byte_write;
    int s0, c0;
    s0 = stb_cnt; c0 = cmt_cnt;
    bus_start;
    put_byte(8'hA0, 1, "R4 control");
    put_byte(8'h35, 1, "R9 address");
    put_byte(8'hA7, 1, "R10 data");
    chk("R10 strobe count", stb_cnt - s0, 1);
    chk("R10 strobe addr", last_a, 8'h35);
    chk("R10 strobe data", last_d, 8'hA7);
    bus_stop; wt(4);
    chk("R12 commit after data", cmt_cnt - c0, 1);
  endtask

  task automatic t_select_ignored;
    int s0;
    s0 = stb_cnt;
    bus_start;
    put_byte(8'hAE, 1, "R4 select bits ignored");
    put_byte(8'h02, 1, "R9 address");
    put_byte(8'h11, 1, "R10 data");
    chk("R4 strobe addr", last_a, 8'h02);
    chk("R4 strobe count", stb_cnt - s0, 1);
    bus_stop; wt(4);
  endtask

  task automatic t_mismatch;
    int s0, c0;
    s0 = stb_cnt; c0 = cmt_cnt;
    bus_start;
    put_byte(8'h90, 0, "R6 wrong code");
    put_byte(8'h10, 0, "R6 later byte");
    put_byte(8'h55, 0, "R6 later byte");
    bus_stop; wt(4);
    chk("R6 no strobe", stb_cnt - s0, 0);
    chk("R6 no commit", cmt_cnt - c0, 0);
  endtask

  task automatic t_busy;
    int s0;
    s0 = stb_cnt;
    busy = 1'b1;
    bus_start;
    put_byte(8'hA0, 0, "R7 busy control");
    put_byte(8'h20, 0, "R7 later byte");
    bus_stop; wt(4);
    busy = 1'b0;
    chk("R7 no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_read;
    int r0;
    r0 = rd_cnt;
    bus_start;
    put_byte(8'hA1, 1, "R8 read control");
    chk("R8 read pulse", rd_cnt - r0, 1);
    put_byte(8'hFF, 0, "R8 byte after read");
    bus_stop; wt(4);
  endtask

  task automatic t_page_wrap;
    bus_start;
    put_byte(8'hA0, 1, "R11 control");
    put_byte(8'h3E, 1, "R11 address");
    put_byte(8'h01, 1, "R11 data0");
    chk("R11 first addr", last_a, 8'h3E);
    put_byte(8'h02, 1, "R11 data1");
    chk("R11 second addr", last_a, 8'h3F);
    put_byte(8'h03, 1, "R11 data2");
    chk("R11 wrapped addr", last_a, 8'h38);
    chk("R11 wrapped data", last_d, 8'h03);
    bus_stop; wt(4);
  endtask

  task automatic t_restart;
    logic o;
    bus_start;
    put_bit(1'b1, o); put_bit(1'b0, o); put_bit(1'b1, o); put_bit(1'b1, o);
    bus_start;
    put_byte(8'hA0, 1, "R2 control after restart");
    put_byte(8'h10, 1, "R2 address");
    put_byte(8'h5A, 1, "R2 data");
    chk("R2 strobe addr", last_a, 8'h10);
    chk("R2 strobe data", last_d, 8'h5A);
    bus_stop; wt(4);
  endtask

  task automatic t_stop_no_data;
    int c0;
    c0 = cmt_cnt;
    bus_start;
    put_byte(8'hA0, 1, "R12 control");
    put_byte(8'h44, 1, "R12 address");
    bus_stop; wt(4);
    chk("R12 no commit without data", cmt_cnt - c0, 0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; busy = 1'b0;
    wt(5);
    chk("R1 oe_n in reset", oe_n, 1);
    rst_n = 1'b1;
    wt(5);
    t_reset;
    t_byte_write;
    t_select_ignored;
    t_mismatch;
    t_busy;
    t_read;
    t_page_wrap;
    t_restart;
    t_stop_no_data;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule